// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM. The host offers one single-word read or write at a time over a valid/ready handshake. The controller turns each request into strobe sequences whose length is worked out from nanosecond-class timing limits. Every limit is a parameter in picoseconds and is converted to a whole number of clock cycles by rounding up, with at least one cycle per phase. The default clock period is 10 ns. After reset, no access is made until a long power-up interval has run out. The RAM is selected with three enables of mixed polarity, which always switch together.

A read presents the address with the enables, the output enable and both byte enables in the same cycle. After the longest of the read limits it samples the bus and returns the word with a one-cycle `rsp_valid` pulse. A write is controlled by the write enable and leaves the output enable low. The write enable falls together with the address, and the controller keeps its bus driver off until the RAM has had time to release the bus. It then drives the data long enough to meet setup, pulse-width and cycle-time limits. Write enable, enables and driver all release on one edge, which is allowed because every hold time is zero. The bus is split into `dq_o`, `dq_i` and the tristate enable `dq_oe`, so the pad sits outside this block.

States are `ST_POWERUP`, `ST_IDLE`, `ST_READ`, `ST_WR_HIZ` and `ST_WR_DRIVE`. The transitions are:
- power-up expiry: `ST_POWERUP` to `ST_IDLE`.
- read accept: `ST_IDLE` to `ST_READ`.
- read sample: `ST_READ` to `ST_IDLE`.
- write accept: `ST_IDLE` to `ST_WR_HIZ`.
- turnaround done: `ST_WR_HIZ` to `ST_WR_DRIVE`.
- write end: `ST_WR_DRIVE` to `ST_IDLE`.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held, the outputs are at rest:
  - `req_ready` and `rsp_valid` are 0.
  - `sram_ce1_n` = 1, `sram_ce2` = 0 and `sram_ce3_n` = 1.
  - `sram_we_n` = 1 and `sram_oe_n` = 1.
  - `sram_be_n` = 2'b11 and `dq_oe` = 0.
- R2: After reset is released, `req_ready` stays low, and no enable is asserted, for exactly ceil(T_POWERUP_PS / CLK_PERIOD_PS) clock edges. Then `req_ready` goes high.
- R3: The three chip enables always agree: `sram_ce1_n` == `sram_ce3_n` and `sram_ce2` == !`sram_ce1_n`.
- R4: A read works as follows:
  - It holds the enables, `sram_oe_n` = 0, `sram_be_n` = 2'b00 and a stable address for max of ceil(tRC, tAA, tDOE, tDBE) cycles.
  - It then returns the bus word on `rsp_rdata` during a single-cycle `rsp_valid` pulse.
- R5: A write holds `sram_we_n` low for at least ceil(tPWE), ceil(tAW), ceil(tBW) and ceil(tWC) cycles. Data is driven on `dq_o` for at least ceil(tSD) cycles before `sram_we_n` rises.
- R6: Bus turnaround works as follows:
  - `dq_oe` is high only while `sram_we_n` is low.
  - `dq_oe` is high no earlier than ceil(tHZWE) cycles after `sram_we_n` falls.
  - The RAM and the controller never drive the bus in the same cycle.
- R7: `req_bmask` bit 0 enables bits [7:0] and bit 1 enables bits [15:8]. A write drives `sram_be_n` = ~`req_bmask`, so only the enabled bytes change, and a mask of 2'b00 changes nothing.
- R8: Write end and address hold:
  - `sram_we_n`, the chip enables and `dq_oe` all release on the same clock edge.
  - `sram_addr` does not change while the enables stay asserted.
- R9: `req_ready` is high only in the idle state, never while the enables are asserted. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. Back-to-back requests are separated by one idle cycle.
- R10: A write never produces an `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_bmask | input | DATA_W/8 | Byte lane enables for writes |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce1_n | output | 1 | Chip enable 1, active low |
| sram_ce2 | output | 1 | Chip enable 2, active high |
| sram_ce3_n | output | 1 | Chip enable 3, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low |
| dq_o | output | DATA_W | Data toward the RAM |
| dq_oe | output | 1 | Tristate enable for `dq_o` |
| dq_i | input | DATA_W | Data from the shared bus |

## Verification
The hardest case is a write issued right after a read. The RAM is still driving the bus with the output enable low, so the gap between the write enable falling and the controller's driver switching on is what keeps the two drivers apart. The bench gets there by queuing alternating reads and writes back to back. Its RAM model drives the bus whenever it is selected with the output enable low and the write enable high. A monitor flags any cycle in which both sides drive. It also flags any driver start that comes too early after the write enable falls, counted in picoseconds from the sampled strobes.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ,
        ST_WR_HIZ,
        ST_WR_DRIVE
    } sram_state_e;

    // round a time in picoseconds up to whole clock cycles, never below one
    function automatic int unsigned ps_to_cycles(input longint unsigned t_ps,
                                                 input longint unsigned clk_ps);
        longint unsigned r;
        r = (t_ps + clk_ps - 1) / clk_ps;
        if (r < 1) r = 1;
        return int'(r);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, floored at one cycle
    function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
        return (a > b + 1) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/async_sram_powerup.sv
module async_sram_powerup #(
    parameter int unsigned N_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CW = $clog2(N_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(N_CYCLES)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // done is high when the next edge completes the interval
    assign done = (cnt_q >= CW'(N_CYCLES - 1));

endmodule

// File: rtl/async_sram_phase_timer.sv
module async_sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != {CW{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/async_sram_datapath.sv
module async_sram_datapath #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_bmask,
    input  logic                  capture,
    input  logic [DATA_W-1:0]     dq_i,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [DATA_W-1:0]     wdata_q,
    output logic [DATA_W/8-1:0]   bmask_q,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            bmask_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            bmask_q <= req_bmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_i;
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import async_sram_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_POWERUP_PS  = 1000000000,
    parameter int unsigned T_RC_PS       = 10000,
    parameter int unsigned T_AA_PS       = 10000,
    parameter int unsigned T_DOE_PS      = 5000,
    parameter int unsigned T_DBE_PS      = 5000,
    parameter int unsigned T_WC_PS       = 10000,
    parameter int unsigned T_PWE_PS      = 7000,
    parameter int unsigned T_SCE_PS      = 7000,
    parameter int unsigned T_AW_PS       = 7000,
    parameter int unsigned T_BW_PS       = 7000,
    parameter int unsigned T_SD_PS       = 5500,
    parameter int unsigned T_HZWE_PS     = 5000,
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_bmask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_ce1_n,
    output logic                sram_ce2,
    output logic                sram_ce3_n,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic [DATA_W/8-1:0] sram_be_n,
    output logic [DATA_W-1:0]   dq_o,
    output logic                dq_oe,
    input  logic [DATA_W-1:0]   dq_i
);
    localparam int unsigned LANES = DATA_W / 8;

    localparam int unsigned N_PU  = ps_to_cycles(T_POWERUP_PS, CLK_PERIOD_PS);
    localparam int unsigned N_RD  = max2(max2(ps_to_cycles(T_RC_PS, CLK_PERIOD_PS),
                                              ps_to_cycles(T_AA_PS, CLK_PERIOD_PS)),
                                         max2(ps_to_cycles(T_DOE_PS, CLK_PERIOD_PS),
                                              ps_to_cycles(T_DBE_PS, CLK_PERIOD_PS)));
    localparam int unsigned N_HZ  = ps_to_cycles(T_HZWE_PS, CLK_PERIOD_PS);
    localparam int unsigned N_WE_MIN = max2(max2(ps_to_cycles(T_PWE_PS, CLK_PERIOD_PS),
                                                 ps_to_cycles(T_SCE_PS, CLK_PERIOD_PS)),
                                            max2(max2(ps_to_cycles(T_AW_PS, CLK_PERIOD_PS),
                                                      ps_to_cycles(T_BW_PS, CLK_PERIOD_PS)),
                                                 ps_to_cycles(T_WC_PS, CLK_PERIOD_PS)));
    localparam int unsigned N_WD  = max2(ps_to_cycles(T_SD_PS, CLK_PERIOD_PS),
                                         sub_floor1(N_WE_MIN, N_HZ));
    localparam int unsigned N_MAXPH = max2(max2(N_RD, N_HZ), N_WD);
    localparam int unsigned CW    = $clog2(N_MAXPH + 1);

    sram_state_e state_q, state_d;

    logic                pu_done;
    logic [CW-1:0]       ph_cnt;
    logic                accept;
    logic                capture;
    logic                phase_restart;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    bmask_q;
    logic                cs_on;

    async_sram_powerup #(
        .N_CYCLES (N_PU)
    ) u_powerup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pu_done)
    );

    async_sram_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .count   (ph_cnt)
    );

    async_sram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_bmask (req_bmask),
        .capture   (capture),
        .dq_i      (dq_i),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .bmask_q   (bmask_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_POWERUP:  if (pu_done) state_d = ST_IDLE;
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_HIZ : ST_READ;
            ST_READ: begin
                if (ph_cnt == CW'(N_RD - 1)) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            ST_WR_HIZ:   if (ph_cnt == CW'(N_HZ - 1)) state_d = ST_WR_DRIVE;
            ST_WR_DRIVE: if (ph_cnt == CW'(N_WD - 1)) state_d = ST_IDLE;
            default:     state_d = ST_POWERUP;
        endcase
    end

    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign phase_restart = (state_d != state_q);

    // outputs decoded from the state register
    always_comb begin
        req_ready = 1'b0;
        cs_on     = 1'b0;
        sram_we_n = 1'b1;
        sram_oe_n = 1'b1;
        sram_be_n = '1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_POWERUP: ;
            ST_IDLE:    req_ready = 1'b1;
            ST_READ: begin
                cs_on     = 1'b1;
                sram_oe_n = 1'b0;
                sram_be_n = '0;
            end
            ST_WR_HIZ: begin
                cs_on     = 1'b1;
                sram_oe_n = 1'b0;
                sram_we_n = 1'b0;
                sram_be_n = ~bmask_q;
            end
            ST_WR_DRIVE: begin
                cs_on     = 1'b1;
                sram_oe_n = 1'b0;
                sram_we_n = 1'b0;
                sram_be_n = ~bmask_q;
                dq_oe     = 1'b1;
            end
            default: ;
        endcase
    end

    assign sram_ce1_n = ~cs_on;
    assign sram_ce2   =  cs_on;
    assign sram_ce3_n = ~cs_on;
    assign sram_addr  = addr_q;
    assign dq_o       = wdata_q;

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned N_PU     = 1,
    parameter int unsigned N_RD     = 1,
    parameter int unsigned N_HZ     = 1,
    parameter int unsigned N_WE_MIN = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_ce3_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              dq_oe
);
    int unsigned since_rst;
    int unsigned we_low;
    int unsigned rd_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 0;
            we_low    <= 0;
            rd_len    <= 0;
        end else begin
            if (since_rst < N_PU) since_rst <= since_rst + 1;
            we_low <= (!sram_we_n) ? we_low + 1 : 0;
            rd_len <= (!sram_ce1_n && !sram_oe_n && sram_we_n) ? rd_len + 1 : 0;
        end
    end

    assert_powerup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> since_rst >= N_PU);

    assert_cs_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce1_n == sram_ce3_n) && (sram_ce2 == !sram_ce1_n));

    assert_read_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rd_len >= N_RD);

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> we_low >= N_WE_MIN);

    assert_drive_needs_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !sram_we_n && !sram_ce1_n);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> we_low >= N_HZ);

    assert_release_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_ce1_n && !dq_oe && !$past(sram_ce1_n));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_ce1_n && sram_we_n);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .N_PU     (N_PU),
    .N_RD     (N_RD),
    .N_HZ     (N_HZ),
    .N_WE_MIN (N_WE_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_ce3_n (sram_ce3_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .dq_oe      (dq_oe)
);

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;
    localparam int TCLK  = 8000;
    localparam int T_PU  = 2000000;
    localparam int EXP_PU = (T_PU + TCLK - 1) / TCLK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] sram_addr;
    logic        ce1_n, ce2, ce3_n, we_n, oe_n, dq_oe;
    logic [1:0]  be_n;
    logic [15:0] dq_o, dq_i;

    always #4ns clk = ~clk;

    async_sram_ctrl #(.CLK_PERIOD_PS(TCLK), .T_POWERUP_PS(T_PU)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_ce3_n(ce3_n),
        .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_be_n(be_n), .dq_o(dq_o),
        .dq_oe(dq_oe), .dq_i(dq_i));

    // RAM model and shadow copy
    logic [15:0] mem    [1024];
    logic [15:0] shadow [1024];
    logic [15:0] exp_q  [$];
    int tests = 0, fails = 0;

    wire cs_act  = !ce1_n && ce2 && !ce3_n;
    wire dev_drv = cs_act && !oe_n && we_n;
    assign dq_i = dq_oe ? dq_o : (dev_drv ? mem[sram_addr[9:0]] : 16'hzzzz);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // monitor: timing, contention and scoreboard
    logic        p_we_n = 1'b1, p_cs = 1'b0, p_oe = 1'b0;
    logic [15:0] p_dq;
    logic [1:0]  p_be;
    logic [19:0] p_addr;
    int we_cyc = 0, drv_cyc = 0, rd_cyc = 0, last_rd = 0;
    logic powerup_seen_ready = 1'b0;

    always @(negedge clk) if (rst_n) begin
        if (!powerup_seen_ready && cs_act) check(0, "R2 enable during power-up", 1, 0);
        if (req_ready) powerup_seen_ready = 1'b1;
        if (!((ce1_n == ce3_n) && (ce2 == !ce1_n))) check(0, "R3 enable mismatch", {ce1_n, ce2, ce3_n}, 0);
        if (dq_oe && dev_drv) check(0, "R6 bus contention", 1, 0);
        if (req_ready && cs_act) check(0, "R9 ready during access", 1, 0);
        if (cs_act && p_cs && sram_addr != p_addr) check(0, "R8 address moved", sram_addr, p_addr);
        if (!we_n) we_cyc++;
        if (dq_oe) drv_cyc++;
        if (dev_drv) rd_cyc++; else if (rd_cyc != 0) begin last_rd = rd_cyc; rd_cyc = 0; end
        if (dq_oe && !p_oe)
            check((we_cyc - 1) * TCLK >= 5000, "R6 driver too early after WE fall", we_cyc - 1, 1);
        if (!p_we_n && we_n) begin
            check(we_cyc * TCLK >= 7000 && we_cyc * TCLK >= 10000, "R5 WE pulse / cycle", we_cyc, 2);
            check(drv_cyc * TCLK >= 5500, "R5 data setup", drv_cyc, 1);
            check(!cs_act && !dq_oe, "R8 release together", {cs_act, dq_oe}, 0);
            if (!p_be[0]) mem[p_addr[9:0]][7:0]  = p_dq[7:0];
            if (!p_be[1]) mem[p_addr[9:0]][15:8] = p_dq[15:8];
            we_cyc = 0; drv_cyc = 0;
        end
        if (rsp_valid) begin
            check(last_rd * TCLK >= 10000, "R4 read window", last_rd, 2);
            if (exp_q.size() == 0) check(0, "R10 unexpected response", rsp_rdata, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rsp_rdata == e, "R4 R7 read data", rsp_rdata, e);
            end
        end
        p_we_n = we_n; p_cs = cs_act; p_oe = dq_oe; p_dq = dq_o; p_be = be_n; p_addr = sram_addr;
    end

    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        if (wr) begin
            if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
            if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
        end else exp_q.push_back(shadow[a[9:0]]);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk); req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 16'(i * 16'h3b1 ^ 16'h5a5a);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check(!req_ready && !rsp_valid && ce1_n && !ce2 && ce3_n && we_n && oe_n
              && be_n == 2'b11 && !dq_oe, "R1 reset state", {ce1_n, ce2, ce3_n, we_n, oe_n}, 5'b10111);
        // hold a read pending through power-up
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'd5;
        exp_q.push_back(shadow[5]);
        rst_n = 1'b1;
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!req_ready && n < 1000);
            check(n == EXP_PU, "R2 power-up length", n, EXP_PU);
        end
        @(posedge clk);
        idle(4);
        // R7 byte lane patterns
        do_req(1, 20'd10, 16'hA1B2, 2'b11);
        do_req(0, 20'd10, 16'h0, 2'b00);
        do_req(1, 20'd11, 16'hC3D4, 2'b01);
        do_req(0, 20'd11, 16'h0, 2'b00);
        do_req(1, 20'd12, 16'hE5F6, 2'b10);
        do_req(0, 20'd12, 16'h0, 2'b00);
        do_req(1, 20'd13, 16'h7788, 2'b00);
        do_req(0, 20'd13, 16'h0, 2'b00);
        idle(6);
        check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
        // R10 writes alone give no response (monitor flags any)
        do_req(1, 20'd20, 16'h1234, 2'b11);
        do_req(1, 20'd21, 16'h5678, 2'b11);
        idle(8);
        // R6 R9 alternating read/write back to back
        for (int k = 0; k < 12; k++) begin
            do_req(0, 20'(30 + k), 16'h0, 2'b00);
            do_req(1, 20'(30 + k), 16'(k * 16'h1111 + 16'h0f0f), 2'(k % 4));
        end
        for (int k = 0; k < 12; k++) do_req(0, 20'(30 + k), 16'h0, 2'b00);
        do_req(1, 20'hFFFFF, 16'hBEEF, 2'b11);
        do_req(0, 20'hFFFFF, 16'h0, 2'b00);
        idle(10);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        summary();
    end
endmodule